// File: doc/BRIEF.md
# Shared-Timebase Multichannel PWM Generator

This block produces several pulse-width-modulated outputs that all share one base frequency. A single 16-bit up-counter is the timebase. Its low byte sweeps through 256 values per PWM period, and each channel compares that byte against its own 8-bit threshold to drive its output pin. Because every channel reads the same counter, all outputs switch at the same period rate and differ only in duty cycle. A low-pass filter placed after an output turns it into a coarse analog level.

Software reaches the block through a single-cycle write port: enable, address and data. A control byte starts or stops the counter and selects what advances it. The counter can step on a slow divided system clock, a fast divided system clock, an overflow pulse from a neighbouring timer, or rising edges of an external pin. Every source arrives as a one-cycle count-enable, so the whole block runs on one clock. Each channel has a duty byte that software may rewrite at any time. The duty byte is copied into the channel's private compare byte only when the counter's low byte rolls over, so a period never mixes two duty values.

Top module: `pwm_array`

## Requirements
- R1: Synchronous active-high reset clears the counter, every duty byte, every compare byte and every mode byte, so all outputs are low and stay low until a channel is configured again.
- R2: The counter advances only while the run flag (bit 6 of the control byte at address 0x00) is 1. Writing it to 0 freezes the count.
- R3: Control bits [2:1] pick the count source. 2'b00 advances the counter once every 6 system clocks and 2'b01 once every 2 system clocks.
- R4: Source code 2'b10 advances the counter once for every clock cycle in which the overflow input is high.
- R5: Source code 2'b11 passes the external pin through a two-flop synchroniser and advances the counter once per rising edge, however long the pin stays high.
- R6: The counter is 16 bits wide. Its low byte wraps from 0xFF to 0x00 every 256 counts, and at that wrap the upper byte goes up by one.
- R7: An enabled channel's output is 1 when the counter low byte is greater than or equal to that channel's compare byte, and 0 otherwise.
- R8: A write to channel n's duty byte (address 0x10+n) reaches the compare byte only on the next low-byte wrap. Until then the output keeps following the old compare byte.
- R9: A duty write issued in the same clock cycle as a wrap is the value that wrap loads.
- R10: A channel produces PWM only when both bit 6 and bit 1 of its mode byte (address 0x08+n) are 1. Other bits do not matter. Any other setting holds the output at 0.
- R11: The five channels take independent duty and mode settings while sharing the one counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 5 | Register address: 0x00 control, 0x08+n mode, 0x10+n duty |
| wr_data | input | 8 | Register write data |
| ovf_pulse_i | input | 1 | Count pulse from a neighbouring timer (source 2'b10) |
| ext_pin_i | input | 1 | Asynchronous external count pin (source 2'b11) |
| timer_o | output | 16 | Current counter value |
| pwm_o | output | 5 | One PWM output per channel |

## Verification
The bench builds the block with its defaults: five channels, an 8-bit duty, a 16-bit counter, and dividers of 6 and 2. With the overflow source held high, the counter steps on every clock, so a full 256-count period takes exactly 256 cycles. This makes every compare threshold, including 0 and 255, reachable in a single sweep, and it lets the bench place a duty write in the exact wrap cycle. The dividers of 6 and 2 are checked by counting steps over windows that are whole multiples of each divider, so the result does not depend on the prescaler phase.

// File: rtl/pwm_array_pkg.sv
package pwm_array_pkg;

    localparam int ADDR_W       = 5;
    localparam int CH_IDX_W     = 3;
    localparam int RUN_BIT      = 6;
    localparam int SRC_LSB      = 1;
    localparam int MODE_CMP_BIT = 6;
    localparam int MODE_PWM_BIT = 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] MODE_BASE = 5'h08;
    localparam logic [ADDR_W-1:0] DUTY_BASE = 5'h10;

    typedef enum logic [1:0] {
        SRC_DIV_SLOW = 2'b00,
        SRC_DIV_FAST = 2'b01,
        SRC_OVF      = 2'b10,
        SRC_EXT      = 2'b11
    } count_src_e;

    typedef struct packed {
        logic       run;
        count_src_e src;
    } ctrl_t;

    typedef struct packed {
        logic cmp_on;
        logic pwm_on;
    } mode_t;

    function automatic logic mode_active(input mode_t m);
        return m.cmp_on & m.pwm_on;
    endfunction

    function automatic logic [ADDR_W-1:0] chan_addr(input logic [ADDR_W-1:0] base,
                                                     input int idx);
        return base + ADDR_W'(idx);
    endfunction

endpackage

// File: rtl/pwm_div.sv
module pwm_div #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic pulse_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign pulse_o = (cnt_q == LAST);
endmodule

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel
    import pwm_array_pkg::*;
#(
    parameter int SLOW_DIV = 6,
    parameter int FAST_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  count_src_e src,
    input  logic       ovf_i,
    input  logic       ext_i,
    output logic       tick_o
);
    logic slow_p, fast_p;
    logic [2:0] ext_sync_q;
    logic ext_rise;

    pwm_div #(.DIV(SLOW_DIV)) u_slow (.clk(clk), .rst(rst), .pulse_o(slow_p));
    pwm_div #(.DIV(FAST_DIV)) u_fast (.clk(clk), .rst(rst), .pulse_o(fast_p));

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_sync_q <= '0;
        end else begin
            ext_sync_q <= {ext_sync_q[1:0], ext_i};
        end
    end

    assign ext_rise = ext_sync_q[1] & ~ext_sync_q[2];

    always_comb begin
        unique case (src)
            SRC_DIV_SLOW: tick_o = slow_p;
            SRC_DIV_FAST: tick_o = fast_p;
            SRC_OVF:      tick_o = ovf_i;
            SRC_EXT:      tick_o = ext_rise;
            default:      tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int TMR_W  = 16,
    parameter int DUTY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    output logic [TMR_W-1:0] count_o,
    output logic             wrap_o
);
    logic [TMR_W-1:0] cnt_q;
    logic step;

    assign step = run & tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + TMR_W'(1);
        end
    end

    assign count_o = cnt_q;
    assign wrap_o  = step & (cnt_q[DUTY_W-1:0] == {DUTY_W{1'b1}});
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_array_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic              duty_wr,
    input  logic [7:0]        wr_data,
    input  logic              wrap,
    input  logic [DUTY_W-1:0] timer_lo,
    output logic [DUTY_W-1:0] cmp_o,
    output logic              en_o,
    output logic              pwm_o
);
    mode_t             mode_q;
    logic [DUTY_W-1:0] duty_q, cmp_q, duty_nxt;

    assign duty_nxt = duty_wr ? wr_data[DUTY_W-1:0] : duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            duty_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (mode_wr) begin
                mode_q.cmp_on <= wr_data[MODE_CMP_BIT];
                mode_q.pwm_on <= wr_data[MODE_PWM_BIT];
            end
            duty_q <= duty_nxt;
            if (wrap) begin
                cmp_q <= duty_nxt;
            end
        end
    end

    assign en_o  = mode_active(mode_q);
    assign cmp_o = cmp_q;
    assign pwm_o = en_o & (timer_lo >= cmp_q);
endmodule

// File: rtl/pwm_array.sv
module pwm_array
    import pwm_array_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int TMR_W    = 16,
    parameter int DUTY_W   = 8,
    parameter int SLOW_DIV = 6,
    parameter int FAST_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              ovf_pulse_i,
    input  logic              ext_pin_i,
    output logic [TMR_W-1:0]  timer_o,
    output logic [NUM_CH-1:0] pwm_o
);
    ctrl_t ctrl_q;
    logic  tick, wrap;
    logic [NUM_CH-1:0]             pwm_en;
    logic [NUM_CH-1:0][DUTY_W-1:0] cmp_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            ctrl_q.run <= wr_data[RUN_BIT];
            ctrl_q.src <= count_src_e'(wr_data[SRC_LSB +: 2]);
        end
    end

    pwm_tick_sel #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_tick (
        .clk(clk), .rst(rst), .src(ctrl_q.src),
        .ovf_i(ovf_pulse_i), .ext_i(ext_pin_i), .tick_o(tick)
    );

    pwm_timebase #(.TMR_W(TMR_W), .DUTY_W(DUTY_W)) u_tb (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .tick(tick),
        .count_o(timer_o), .wrap_o(wrap)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic mode_wr_i, duty_wr_i;
        assign mode_wr_i = wr_en && (wr_addr == chan_addr(MODE_BASE, i));
        assign duty_wr_i = wr_en && (wr_addr == chan_addr(DUTY_BASE, i));

        pwm_channel #(.DUTY_W(DUTY_W)) u_ch (
            .clk(clk), .rst(rst),
            .mode_wr(mode_wr_i), .duty_wr(duty_wr_i), .wr_data(wr_data),
            .wrap(wrap), .timer_lo(timer_o[DUTY_W-1:0]),
            .cmp_o(cmp_all[i]), .en_o(pwm_en[i]), .pwm_o(pwm_o[i])
        );
    end
endmodule

// File: rtl/pwm_array_chk.sv
module pwm_array_chk #(
    parameter int NUM_CH = 5,
    parameter int TMR_W  = 16,
    parameter int DUTY_W = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          run,
    input logic                          tick,
    input logic                          wrap,
    input logic [TMR_W-1:0]              timer,
    input logic [NUM_CH-1:0][DUTY_W-1:0] cmp,
    input logic [NUM_CH-1:0]             pwm_en,
    input logic [NUM_CH-1:0]             pwm
);
    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(timer));

    assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
        (run && tick) |=> (timer - $past(timer)) == TMR_W'(1));

    assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> timer[DUTY_W-1:0] == '0);

    assert_cmp_only_at_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cmp));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        assert_off_is_low_R10: assert property (@(posedge clk) disable iff (rst)
            !pwm_en[i] |-> !pwm[i]);
    end
endmodule

bind pwm_array pwm_array_chk #(.NUM_CH(NUM_CH), .TMR_W(TMR_W), .DUTY_W(DUTY_W)) u_chk (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .tick(tick), .wrap(wrap),
    .timer(timer_o), .cmp(cmp_all), .pwm_en(pwm_en), .pwm(pwm_o)
);

// File: tb/pwm_array_bench.sv
module pwm_array_bench;
    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        ovf_pulse_i;
    logic        ext_pin_i;
    logic [15:0] timer_o;
    logic [NCH-1:0] pwm_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_array u_pwm_array (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ovf_pulse_i(ovf_pulse_i), .ext_pin_i(ext_pin_i),
        .timer_o(timer_o), .pwm_o(pwm_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_lo(input logic [7:0] v);
        while (timer_o[7:0] != v) @(negedge clk);
    endtask

    task automatic wait_wrap();
        @(negedge clk);
        wait_lo(8'hFF);
        @(negedge clk);
    endtask

    task automatic span(input int n, output int delta);
        logic [15:0] t0;
        t0 = timer_o;
        repeat (n) @(negedge clk);
        delta = int'(16'(timer_o - t0));
    endtask

    task automatic scan_period(input int cmpv[NCH], input bit en[NCH], input string req);
        int bad[NCH];
        for (int c = 0; c < NCH; c++) bad[c] = 0;
        for (int k = 0; k < 256; k++) begin
            for (int c = 0; c < NCH; c++) begin
                bit e;
                e = en[c] && (int'(timer_o[7:0]) >= cmpv[c]);
                if (pwm_o[c] !== e) bad[c]++;
            end
            @(negedge clk);
        end
        for (int c = 0; c < NCH; c++)
            check(bad[c] == 0, req, $sformatf("channel %0d mismatching cycles", c), bad[c], 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(timer_o == 0, "R1", "timer in reset", timer_o, 0);
        check(pwm_o == 0, "R1", "outputs in reset", pwm_o, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_run_gate();
        int d;
        ovf_pulse_i = 1'b1;
        wr(5'h00, 8'h04);
        span(20, d);
        check(d == 0, "R2", "steps while stopped", d, 0);
        wr(5'h00, 8'h44);
        span(20, d);
        check(d == 20, "R2", "steps while running", d, 20);
        wr(5'h00, 8'h04);
        span(20, d);
        check(d == 0, "R2", "steps after stop", d, 0);
    endtask

    task automatic t_dividers();
        int d;
        wr(5'h00, 8'h42);
        span(40, d);
        check(d == 20, "R3", "fast divider steps in 40 clocks", d, 20);
        wr(5'h00, 8'h40);
        span(60, d);
        check(d == 10, "R3", "slow divider steps in 60 clocks", d, 10);
    endtask

    task automatic t_ovf();
        logic [15:0] t0;
        int d;
        wr(5'h00, 8'h44);
        t0 = timer_o;
        for (int k = 0; k < 30; k++) begin
            ovf_pulse_i = (k % 3 == 0);
            @(negedge clk);
        end
        ovf_pulse_i = 1'b0;
        repeat (3) @(negedge clk);
        d = int'(16'(timer_o - t0));
        check(d == 10, "R4", "overflow pulses counted", d, 10);
    endtask

    task automatic t_ext();
        logic [15:0] t0;
        int d;
        ovf_pulse_i = 1'b1;
        wr(5'h00, 8'h46);
        repeat (4) @(negedge clk);
        t0 = timer_o;
        for (int p = 0; p < 5; p++) begin
            ext_pin_i = 1'b1;
            repeat (4 + p) @(negedge clk);
            ext_pin_i = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        d = int'(16'(timer_o - t0));
        check(d == 5, "R5", "external rising edges counted", d, 5);
    endtask

    task automatic t_wrap();
        logic [7:0] hi;
        ovf_pulse_i = 1'b1;
        wr(5'h00, 8'h44);
        wait_lo(8'hFF);
        hi = timer_o[15:8];
        @(negedge clk);
        check(timer_o[7:0] == 0, "R6", "low byte after wrap", timer_o[7:0], 0);
        check(timer_o[15:8] == 8'(hi + 1), "R6", "high byte after wrap",
              timer_o[15:8], int'(8'(hi + 1)));
    endtask

    task automatic t_duty_set1();
        int cv[NCH] = '{64, 0, 255, 128, 200};
        bit en[NCH] = '{1, 1, 1, 0, 1};
        wr(5'h08, 8'h42); wr(5'h09, 8'h42); wr(5'h0A, 8'h42);
        wr(5'h0B, 8'h40); wr(5'h0C, 8'h42);
        for (int c = 0; c < NCH; c++) wr(5'(16 + c), 8'(cv[c]));
        wait_wrap();
        scan_period(cv, en, "R7/R10");
    endtask

    task automatic t_duty_set2();
        int cv[NCH] = '{1, 128, 127, 10, 254};
        bit en[NCH] = '{1, 1, 1, 1, 1};
        wr(5'h0B, 8'hC2);
        for (int c = 0; c < NCH; c++) wr(5'(16 + c), 8'(cv[c]));
        wait_wrap();
        scan_period(cv, en, "R11");
        wr(5'h0B, 8'h02);
        wait_lo(8'd50);
        check(pwm_o[3] == 1'b0, "R10", "channel 3 with only bit 1 set", pwm_o[3], 0);
    endtask

    task automatic t_double_buffer();
        wait_lo(8'd100);
        wr(5'h10, 8'd200);
        wait_lo(8'd150);
        check(pwm_o[0] == 1'b1, "R8", "old duty kept mid-period", pwm_o[0], 1);
        wait_lo(8'd10);
        check(pwm_o[0] == 1'b0, "R8", "new duty after wrap", pwm_o[0], 0);
        wait_lo(8'd200);
        check(pwm_o[0] == 1'b1, "R8", "new duty threshold reached", pwm_o[0], 1);
    endtask

    task automatic t_same_cycle();
        wait_lo(8'hFF);
        wr(5'h11, 8'd50);
        wait_lo(8'd49);
        check(pwm_o[1] == 1'b0, "R9", "below wrap-cycle duty", pwm_o[1], 0);
        @(negedge clk);
        check(pwm_o[1] == 1'b1, "R9", "at wrap-cycle duty", pwm_o[1], 1);
    endtask

    task automatic t_reset_clears();
        int seen;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(timer_o == 0, "R1", "timer after mid-run reset", timer_o, 0);
        ovf_pulse_i = 1'b1;
        wr(5'h00, 8'h44);
        seen = 0;
        for (int k = 0; k < 300; k++) begin
            if (pwm_o != 0) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R1", "outputs with cleared modes", seen, 0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        ovf_pulse_i = 1'b0; ext_pin_i = 1'b0;
        @(negedge clk);
        t_reset();
        t_run_gate();
        t_dividers();
        t_ovf();
        t_ext();
        t_wrap();
        t_duty_set1();
        t_duty_set2();
        t_double_buffer();
        t_same_cycle();
        t_reset_clears();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule